// File: doc/BRIEF.md
# Flash Reset and Ready Sequencer

This block sits at the front end of a parallel NOR-style flash model and handles its active-low hardware reset line. It counts how long that line has been held low and rejects glitches shorter than a minimum width. When a reset qualifies, it sends a one-cycle abort to the program/erase engine and a one-cycle request to return the command state machine to the read-array state. It also raises a flag that makes the command decoder ignore commands, and it forces the data bus to high impedance until the line is released.

After a reset is accepted, the ready/busy output stays low for a completion interval. The length of that interval depends on whether the engine was busy in the cycle the reset qualified. Once the line goes high again, reads stay blocked for a separate recovery interval. The output-enable and chip-enable strobes control the bus drive at all other times. All analog timings are parameters counted in clock cycles.

Top module: `flash_rst_seq`

## Requirements
- R1: A low level on `flash_reset_n` that is sampled on fewer than TRP consecutive clock edges has no effect. `abort_o` and `cmd_ignore_o` stay 0, and `ready_o`, `bus_drive_o` and `read_ok_o` keep their values. The low-count restarts from zero whenever the line is sampled high.
- R2: On the clock edge that samples the TRP-th consecutive low level, `abort_o` and `read_array_req_o` rise together. Both stay high for exactly one cycle.
- R3: `cmd_ignore_o` rises on the acceptance edge. It falls on the first clock edge that samples `flash_reset_n` high.
- R4: While `cmd_ignore_o` is 1, `bus_drive_o` is 0.
- R5: If `eng_busy_i` is 1 on the acceptance edge, `ready_o` is 0 for exactly TREADY_BUSY cycles starting with the acceptance edge. It then returns to 1 if `eng_busy_i` is 0.
- R6: If `eng_busy_i` is 0 on the acceptance edge, `ready_o` is 0 for exactly TREADY_IDLE cycles starting with the acceptance edge.
- R7: The completion interval is set only by the `eng_busy_i` value sampled on the acceptance edge. Later changes of `eng_busy_i` neither shorten nor lengthen it.
- R8: A new acceptance while a completion interval is still running restarts the interval from the new acceptance edge. The new length is chosen from the new busy sample.
- R9: `read_ok_o` is 1 only when `ready_o` is 1 and at least TRH clock edges have sampled `flash_reset_n` high since the last accepted reset was held. `read_ok_o` is 0 for the TRH cycles that follow the release edge.
- R10: Outside an accepted reset, `bus_drive_o` is 1 exactly when `oe_n_i` and `ce_n_i` were both 0 at the previous clock edge. It is 0 whenever `oe_n_i` was 1.
- R11: `ready_o` is a registered output. Outside a completion interval it equals the inverse of `eng_busy_i` as sampled at the previous clock edge.
- R12: A reset held low for any length after acceptance produces only one abort pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low system reset |
| flash_reset_n | input | 1 | Active-low hardware reset line being qualified |
| eng_busy_i | input | 1 | 1 while the program/erase engine is running |
| ce_n_i | input | 1 | Active-low chip enable |
| oe_n_i | input | 1 | Active-low output enable |
| abort_o | output | 1 | One-cycle abort to the embedded algorithm engine |
| read_array_req_o | output | 1 | One-cycle request to return the command state machine to read-array |
| cmd_ignore_o | output | 1 | 1 while commands must be ignored |
| ready_o | output | 1 | Ready/busy output, 1 = ready, 0 = busy |
| bus_drive_o | output | 1 | 1 = drive the data bus, 0 = high impedance |
| read_ok_o | output | 1 | 1 when array reads are permitted |

## Verification
A low-count that is off by one shows up at `abort_o`: the pulse arrives one edge early or late, or it is missing after exactly TRP low samples. A mis-captured busy sample shows up as a `ready_o` low window that has the other interval's length. A completion counter that does not reload on a second acceptance releases `ready_o` at the old deadline, which is at most TREADY_BUSY cycles after the first abort. A recovery counter that is not loaded during the hold shows `read_ok_o` high on the first cycle after release.

// File: rtl/frs_pkg.sv
// Package: shared types and helpers for the flash reset sequencer.
// Assumes: counter widths are derived from cycle-count parameters >= 1.
package frs_pkg;

    // Which completion interval applies to the current reset
    typedef enum logic {
        DONE_IDLE = 1'b0,
        DONE_BUSY = 1'b1
    } done_sel_e;

    // Bits needed to hold the value maxv (at least one bit)
    function automatic int cnt_bits(input int maxv);
        return (maxv < 2) ? 1 : $clog2(maxv + 1);
    endfunction

endpackage

// File: rtl/frs_pulse_qual.sv
// Module: qualifies the active-low hardware reset line by its pulse width.
// A reset is accepted on the edge that samples the TRP-th consecutive low
// level. The count saturates, so a long hold is accepted only once.
// Assumes: TRP >= 1, and line_n is already synchronous to clk.
module frs_pulse_qual #(
    parameter int TRP = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_n,
    output logic accept_now,
    output logic hold_next,
    output logic hold_q,
    output logic abort_q,
    output logic rda_req_q
);
    import frs_pkg::*;

    localparam int              W   = cnt_bits(TRP);
    localparam logic [W-1:0]    LIM = W'(TRP);

    logic [W-1:0] low_cnt;

    assign accept_now = !line_n && (low_cnt == LIM - 1'b1);
    assign hold_next  = accept_now || (hold_q && !line_n);

    // Count consecutive low samples, clear on any high sample, saturate at TRP
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            low_cnt <= '0;
        end else if (line_n) begin
            low_cnt <= '0;
        end else if (low_cnt != LIM) begin
            low_cnt <= low_cnt + 1'b1;
        end
    end

    // Track the held state of an accepted reset
    always_ff @(posedge clk) begin
        if (!rst_n) hold_q <= 1'b0;
        else        hold_q <= hold_next;
    end

    // One-cycle abort and return-to-read-array pulses on acceptance
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            abort_q   <= 1'b0;
            rda_req_q <= 1'b0;
        end else begin
            abort_q   <= accept_now;
            rda_req_q <= accept_now;
        end
    end

endmodule

// File: rtl/frs_done_timer.sv
// Module: completion timer that drives the registered ready/busy output.
// On acceptance it captures the engine busy flag. That captured flag alone
// selects the terminal count TB or TI. Ready stays low for exactly that many
// cycles, counting from the acceptance edge. A new acceptance restarts it.
// Assumes: TB >= 1 and TI >= 1.
module frs_done_timer #(
    parameter int TB = 12,
    parameter int TI = 5
) (
    input  logic clk,
    input  logic rst_n,
    input  logic accept_now,
    input  logic eng_busy,
    output logic ready_q
);
    import frs_pkg::*;

    localparam int           TMAX  = (TB > TI) ? TB : TI;
    localparam int           W     = cnt_bits(TMAX);
    localparam logic [W-1:0] LIM_B = W'(TB);
    localparam logic [W-1:0] LIM_I = W'(TI);

    done_sel_e    sel_q;
    logic         run_q;
    logic [W-1:0] cnt_q;
    logic [W-1:0] limit;

    // Terminal count chosen from the captured busy flag
    assign limit = (sel_q == DONE_BUSY) ? LIM_B : LIM_I;

    // Capture the busy flag at acceptance only
    always_ff @(posedge clk) begin
        if (!rst_n)          sel_q <= DONE_IDLE;
        else if (accept_now) sel_q <= eng_busy ? DONE_BUSY : DONE_IDLE;
    end

    // Run the interval counter and produce the registered ready output
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q   <= 1'b0;
            cnt_q   <= '0;
            ready_q <= 1'b1;
        end else if (accept_now) begin
            run_q   <= 1'b1;
            cnt_q   <= W'(1);
            ready_q <= 1'b0;
        end else if (run_q) begin
            if (cnt_q == limit) begin
                run_q   <= 1'b0;
                cnt_q   <= '0;
                ready_q <= !eng_busy;
            end else begin
                cnt_q   <= cnt_q + 1'b1;
                ready_q <= 1'b0;
            end
        end else begin
            ready_q <= !eng_busy;
        end
    end

endmodule

// File: rtl/frs_recovery.sv
// Module: read-recovery counter after an accepted reset is released.
// The counter is loaded with TRH on every edge where the held state is set.
// It then counts down once per edge; reads are allowed again at zero.
// Assumes: TRH >= 0. TRH = 0 selects a variant with no counter.
module frs_recovery #(
    parameter int TRH = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic hold_q,
    output logic rec_done
);
    import frs_pkg::*;

    generate
        if (TRH == 0) begin : g_none
            assign rec_done = 1'b1;
        end else begin : g_cnt
            localparam int           W   = cnt_bits(TRH);
            localparam logic [W-1:0] LIM = W'(TRH);
            logic [W-1:0] rec_cnt;

            // Reload while held, count down after release
            always_ff @(posedge clk) begin
                if (!rst_n)               rec_cnt <= '0;
                else if (hold_q)          rec_cnt <= LIM;
                else if (rec_cnt != '0)   rec_cnt <= rec_cnt - 1'b1;
            end

            assign rec_done = (rec_cnt == '0);
        end
    endgenerate

endmodule

// File: rtl/frs_bus_ctrl.sv
// Module: data bus drive control and read-permitted flag.
// The bus is driven only when both enables are low and no accepted reset is
// held. read_ok combines registered state only, so it has no path from an input.
// Assumes: the strobes are synchronous to clk.
module frs_bus_ctrl (
    input  logic clk,
    input  logic rst_n,
    input  logic oe_n,
    input  logic ce_n,
    input  logic hold_next,
    input  logic hold_q,
    input  logic ready_q,
    input  logic rec_done,
    output logic drive_q,
    output logic read_ok
);

    // Register the bus drive enable
    always_ff @(posedge clk) begin
        if (!rst_n) drive_q <= 1'b0;
        else        drive_q <= !oe_n && !ce_n && !hold_next;
    end

    // Reads need recovery done, ready high and no held reset
    assign read_ok = rec_done && ready_q && !hold_q;

endmodule

// File: rtl/flash_rst_seq.sv
// Module: top of the flash reset and ready sequencer.
// Connects the pulse qualifier, completion timer, recovery counter and bus
// control. All outputs come from registers or from gates on registers.
// Assumes: all inputs are synchronous to clk; rst_n is a synchronous reset.
module flash_rst_seq #(
    parameter int TRP         = 4,
    parameter int TREADY_BUSY = 12,
    parameter int TREADY_IDLE = 5,
    parameter int TRH         = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic flash_reset_n,
    input  logic eng_busy_i,
    input  logic ce_n_i,
    input  logic oe_n_i,
    output logic abort_o,
    output logic read_array_req_o,
    output logic cmd_ignore_o,
    output logic ready_o,
    output logic bus_drive_o,
    output logic read_ok_o
);

    logic accept_now;
    logic hold_next;
    logic hold_q;
    logic rec_done;

    frs_pulse_qual #(.TRP(TRP)) u_qual (
        .clk        (clk),
        .rst_n      (rst_n),
        .line_n     (flash_reset_n),
        .accept_now (accept_now),
        .hold_next  (hold_next),
        .hold_q     (hold_q),
        .abort_q    (abort_o),
        .rda_req_q  (read_array_req_o)
    );

    frs_done_timer #(.TB(TREADY_BUSY), .TI(TREADY_IDLE)) u_done (
        .clk        (clk),
        .rst_n      (rst_n),
        .accept_now (accept_now),
        .eng_busy   (eng_busy_i),
        .ready_q    (ready_o)
    );

    frs_recovery #(.TRH(TRH)) u_rec (
        .clk      (clk),
        .rst_n    (rst_n),
        .hold_q   (hold_q),
        .rec_done (rec_done)
    );

    frs_bus_ctrl u_bus (
        .clk       (clk),
        .rst_n     (rst_n),
        .oe_n      (oe_n_i),
        .ce_n      (ce_n_i),
        .hold_next (hold_next),
        .hold_q    (hold_q),
        .ready_q   (ready_o),
        .rec_done  (rec_done),
        .drive_q   (bus_drive_o),
        .read_ok   (read_ok_o)
    );

    assign cmd_ignore_o = hold_q;

endmodule

// File: rtl/frs_seq_chk.sv
// Module: checker for the flash reset sequencer, bound to the top module.
// Assumes: it observes ports only; every property is disabled during rst_n.
module frs_seq_chk #(
    parameter int TRH = 3
) (
    input logic clk,
    input logic rst_n,
    input logic flash_reset_n,
    input logic oe_n_i,
    input logic abort_o,
    input logic read_array_req_o,
    input logic cmd_ignore_o,
    input logic ready_o,
    input logic bus_drive_o,
    input logic read_ok_o
);

    // R2
    abort_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        abort_o |=> !abort_o);

    // R2
    abort_with_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        abort_o |-> read_array_req_o);

    // R1
    abort_after_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        abort_o |-> $past(!flash_reset_n));

    // R3
    abort_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
        abort_o |-> cmd_ignore_o);

    // R4
    ignore_no_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_ignore_o |-> !bus_drive_o);

    // R10
    oe_high_no_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(oe_n_i) |-> !bus_drive_o);

    // R5
    abort_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        abort_o |-> !ready_o);

    // R9
    read_needs_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        read_ok_o |-> ready_o);

    // R9
    release_blocks_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((TRH > 0) && $fell(cmd_ignore_o)) |-> !read_ok_o);

endmodule

bind flash_rst_seq frs_seq_chk #(.TRH(TRH)) u_chk (
    .clk              (clk),
    .rst_n            (rst_n),
    .flash_reset_n    (flash_reset_n),
    .oe_n_i           (oe_n_i),
    .abort_o          (abort_o),
    .read_array_req_o (read_array_req_o),
    .cmd_ignore_o     (cmd_ignore_o),
    .ready_o          (ready_o),
    .bus_drive_o      (bus_drive_o),
    .read_ok_o        (read_ok_o)
);

// File: tb/tb_flash_rst_seq.sv
// Directed bench for the flash reset sequencer. There is one task per
// scenario. Inputs change and outputs are sampled 1 time unit after each
// rising edge.
module tb_flash_rst_seq;

    localparam int CLK_PERIOD = 10;
    localparam int P_TRP      = 4;
    localparam int P_TB       = 12;
    localparam int P_TI       = 5;
    localparam int P_TRH      = 3;

    logic clk = 1'b0;
    logic rst_n;
    logic flash_reset_n;
    logic eng_busy_i;
    logic ce_n_i;
    logic oe_n_i;
    logic abort_o;
    logic read_array_req_o;
    logic cmd_ignore_o;
    logic ready_o;
    logic bus_drive_o;
    logic read_ok_o;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    flash_rst_seq #(
        .TRP(P_TRP), .TREADY_BUSY(P_TB), .TREADY_IDLE(P_TI), .TRH(P_TRH)
    ) dut (
        .clk              (clk),
        .rst_n            (rst_n),
        .flash_reset_n    (flash_reset_n),
        .eng_busy_i       (eng_busy_i),
        .ce_n_i           (ce_n_i),
        .oe_n_i           (oe_n_i),
        .abort_o          (abort_o),
        .read_array_req_o (read_array_req_o),
        .cmd_ignore_o     (cmd_ignore_o),
        .ready_o          (ready_o),
        .bus_drive_o      (bus_drive_o),
        .read_ok_o        (read_ok_o)
    );

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic check(input string req, input string what,
                         input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %b expected %b at %0t", req, what, act, exp, $time);
        end
    endtask

    task automatic t_reset_state();
        check("R2",  "abort after reset", abort_o, 1'b0);
        check("R3",  "ignore after reset", cmd_ignore_o, 1'b0);
        check("R11", "ready after reset", ready_o, 1'b1);
        check("R10", "drive after reset", bus_drive_o, 1'b0);
        check("R9",  "read_ok after reset", read_ok_o, 1'b1);
    endtask

    task automatic t_bus_ctrl();
        oe_n_i = 1'b0; ce_n_i = 1'b0; step();
        check("R10", "drive both enables low", bus_drive_o, 1'b1);
        oe_n_i = 1'b1; step();
        check("R10", "drive with oe high", bus_drive_o, 1'b0);
        oe_n_i = 1'b0; ce_n_i = 1'b1; step();
        check("R10", "drive with ce high", bus_drive_o, 1'b0);
        ce_n_i = 1'b0; step();
        check("R10", "drive restored", bus_drive_o, 1'b1);
    endtask

    task automatic t_busy_follow();
        eng_busy_i = 1'b1; step();
        check("R11", "ready follows busy", ready_o, 1'b0);
        check("R9",  "read_ok needs ready", read_ok_o, 1'b0);
        eng_busy_i = 1'b0; step();
        check("R11", "ready follows idle", ready_o, 1'b1);
        check("R9",  "read_ok with ready", read_ok_o, 1'b1);
    endtask

    task automatic t_short_pulse();
        for (int p = 0; p < 2; p++) begin
            flash_reset_n = 1'b0;
            for (int i = 0; i < P_TRP - 1; i++) begin
                step();
                check("R1", "abort on short pulse", abort_o, 1'b0);
                check("R1", "ignore on short pulse", cmd_ignore_o, 1'b0);
            end
            flash_reset_n = 1'b1; step();
            check("R1", "abort after short pulse", abort_o, 1'b0);
            check("R1", "ready after short pulse", ready_o, 1'b1);
            check("R1", "drive after short pulse", bus_drive_o, 1'b1);
            check("R1", "read_ok after short pulse", read_ok_o, 1'b1);
        end
    endtask

    task automatic t_accept(input logic busy_at, input int t_len, input string req);
        eng_busy_i = busy_at;
        flash_reset_n = 1'b0;
        for (int i = 0; i < P_TRP - 1; i++) step();
        check("R1", "no abort before TRP", abort_o, 1'b0);
        step();
        check("R2", "abort on accept", abort_o, 1'b1);
        check("R2", "read-array request on accept", read_array_req_o, 1'b1);
        check("R3", "ignore on accept", cmd_ignore_o, 1'b1);
        check("R4", "no drive while held", bus_drive_o, 1'b0);
        check(req,  "busy on accept", ready_o, 1'b0);
        eng_busy_i = !busy_at;
        step();
        check("R2", "abort one cycle", abort_o, 1'b0);
        check("R2", "request one cycle", read_array_req_o, 1'b0);
        check(req,  "busy window", ready_o, 1'b0);
        for (int i = 2; i < t_len; i++) begin
            step();
            check("R7", "busy window after busy flip", ready_o, 1'b0);
        end
        eng_busy_i = 1'b0;
        step();
        check(req,  "ready at end of window", ready_o, 1'b1);
        check("R12", "no second abort while held", abort_o, 1'b0);
        check("R3", "ignore still held", cmd_ignore_o, 1'b1);
        check("R9", "no read while held", read_ok_o, 1'b0);
        flash_reset_n = 1'b1;
        step();
        check("R3", "ignore drops on release", cmd_ignore_o, 1'b0);
        check("R10", "drive after release", bus_drive_o, 1'b1);
        check("R9", "read blocked after release", read_ok_o, 1'b0);
        for (int k = 2; k <= P_TRH; k++) begin
            step();
            check("R9", "read blocked in recovery", read_ok_o, 1'b0);
        end
        step();
        check("R9", "read allowed after recovery", read_ok_o, 1'b1);
    endtask

    task automatic t_restart();
        eng_busy_i = 1'b1;
        flash_reset_n = 1'b0;
        for (int i = 0; i < P_TRP; i++) step();
        check("R8", "first accept", abort_o, 1'b1);
        eng_busy_i = 1'b0;
        for (int i = 0; i < 3; i++) step();
        flash_reset_n = 1'b1; step();
        check("R8", "still busy after brief release", ready_o, 1'b0);
        flash_reset_n = 1'b0;
        for (int i = 0; i < P_TRP - 1; i++) step();
        step();
        check("R8", "second accept", abort_o, 1'b1);
        check("R8", "busy at second accept", ready_o, 1'b0);
        for (int i = 1; i < P_TI; i++) begin
            step();
            check("R8", "restarted window", ready_o, 1'b0);
        end
        step();
        check("R8", "ready after restarted idle window", ready_o, 1'b1);
        flash_reset_n = 1'b1;
        for (int i = 0; i <= P_TRH; i++) step();
        check("R9", "read allowed after restart", read_ok_o, 1'b1);
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    endtask

    initial begin
        rst_n = 1'b0; flash_reset_n = 1'b1; eng_busy_i = 1'b0;
        ce_n_i = 1'b1; oe_n_i = 1'b1;
        repeat (3) step();
        rst_n = 1'b1;
        step();
        t_reset_state();
        t_bus_ctrl();
        t_busy_follow();
        t_short_pulse();
        t_accept(1'b1, P_TB, "R5");
        t_accept(1'b0, P_TI, "R6");
        t_restart();
        done = 1'b1;
        summary();
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog all-reqs: actual hung, expected completion");
            summary();
            $finish;
        end
    end

endmodule